// File: doc/BRIEF.md
# AES-128 Key-Expansion Step Engine for Vector Element Groups

This engine runs one forward AES-128 key-expansion step on every 128-bit element group of a vector source operand. Each group holds four 32-bit elements that form the current round key. The engine writes the next round key into the destination group with the same index. A 4-bit round immediate selects the round constant. Immediates outside the valid round range are folded back into it, so they are never rejected.

A command supplies the immediate, the element-width code, vstart and vl. The engine first checks the command. For a legal command it walks the groups in ascending order, one per cycle. It reads each group through a combinational read port and writes the result through a write port one cycle later. It ends with a one-cycle done pulse. An illegal command ends with a one-cycle illegal pulse instead, and nothing is written. The element groups cannot be masked.

Top module: `aes_kstep_unit`

## Requirements
- R1: The effective round is taken from round_imm_i[3:0]. For a value of 0, or a value above 10, bit 3 is inverted (0→8, 11→3, 12→4, 13→5, 14→6, 15→7). The effective round is always in 1..10. Its constant is 01,02,04,08,10,20,40,80,1B,36 for rounds 1..10, placed in byte 0 of the word.
- R2: Within a group, bits [31:0] hold key word w0 and bits [127:96] hold w3, and byte 0 of each word is its least significant byte. The result is built as follows. Rotate w3 so that byte 1 becomes byte 0. Apply the AES S-box to each byte. XOR the result with w0 and with the round constant to give w4. Then w5=w1^w4, w6=w2^w5 and w7=w3^w6. The output group is {w7,w6,w5,w4}.
- R3: sew_i encodes the element width as 3'b010 for 32 bits. Any other code makes illegal_o pulse high in the cycle after the start edge, with no write and no done_o.
- R4: If vstart_i or vl_i is not a multiple of 4, illegal_o pulses in the same way and nothing is written. This check takes priority over R5.
- R5: A legal command with vstart_i >= vl_i raises done_o in the cycle after the start edge, with no write and no illegal_o.
- R6: Groups vstart_i/4 through vl_i/4−1 are processed in ascending order. The read of group k happens in the k-th cycle after the start edge, counting from 0 at the first group. Its write (wr_en_o, wr_grp_o, wr_data_o) is presented in the following cycle.
- R7: For N groups, done_o is high for exactly one cycle, N+1 cycles after the cycle that follows the start edge. done_o and illegal_o are never high together.
- R8: Every group in the range is written exactly once. No group outside the range is written.
- R9: start_i is ignored while busy_o is high, including in the final cycle before done_o.
- R10: While reset is held, rd_en_o, wr_en_o, done_o, illegal_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, sampled when idle |
| round_imm_i | input | 4 | Round immediate |
| sew_i | input | 3 | Element-width code (3'b010 = 32 bits) |
| vstart_i | input | VL_W | First element index |
| vl_i | input | VL_W | Vector length in elements (at most MAX_ELEMS) |
| rd_en_o | output | 1 | Source read strobe |
| rd_grp_o | output | GRP_W | Source group index |
| rd_data_i | input | 128 | Source group data, same cycle as rd_grp_o |
| wr_en_o | output | 1 | Destination write strobe |
| wr_grp_o | output | GRP_W | Destination group index |
| wr_data_o | output | 128 | Next round key |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle illegal-configuration pulse |

## Verification
The bench drives inputs on falling edges and counts falling edges from the start edge. An illegal or empty command must show its flag at count 1. Write k of a legal run must appear at count k+2, and done_o at count N+2. At each count where wr_en_o is high, the bench compares the group index and data against a model built from an S-box generated inside the bench. One count after each flag, it confirms that the flag has dropped and that no write is pending. The destination image is then compared group by group, both inside and outside the range.

// File: rtl/aes_kstep_pkg.sv
package aes_kstep_pkg;
  localparam logic [2:0] SEW_E32 = 3'b010;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} kstep_state_e;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // x^254 == multiplicative inverse, 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] base;
    logic [7:0] ex;
    res  = 8'h01;
    base = a;
    ex   = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (ex[i]) res = gf_mul(res, base);
      base = gf_mul(base, base);
    end
    return res;
  endfunction

  function automatic logic [3:0] fold_round(input logic [3:0] r);
    return ((r == 4'd0) || (r > 4'd10)) ? (r ^ 4'h8) : r;
  endfunction

  function automatic logic [7:0] round_const(input logic [3:0] r);
    logic [7:0] c;
    c = 8'h01;
    for (int i = 2; i <= 10; i++) begin
      if (i <= int'(r)) c = gf_xtime(c);
    end
    return c;
  endfunction
endpackage

// File: rtl/aes_kstep_sbox.sv
module aes_kstep_sbox (
  input  logic [7:0] in_i,
  output logic [7:0] out_o
);
  import aes_kstep_pkg::*;

  logic [7:0] inv;

  always_comb begin
    inv   = gf_inv(in_i);
    out_o = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
          ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  end
endmodule

// File: rtl/aes_kstep_core.sv
module aes_kstep_core #(
  parameter int WORD_W = 32,
  parameter int N_WORDS = 4
) (
  input  logic [3:0]                round_i,
  input  logic [WORD_W*N_WORDS-1:0] key_i,
  output logic [WORD_W*N_WORDS-1:0] key_o
);
  import aes_kstep_pkg::*;

  localparam int N_BYTES = WORD_W / 8;

  logic [WORD_W-1:0] w_in  [N_WORDS];
  logic [WORD_W-1:0] w_out [N_WORDS];
  logic [WORD_W-1:0] rot_w;
  logic [WORD_W-1:0] sub_w;

  for (genvar i = 0; i < N_WORDS; i++) begin : g_words
    assign w_in[i] = key_i[i*WORD_W +: WORD_W];
    assign key_o[i*WORD_W +: WORD_W] = w_out[i];
  end

  // rotate so byte 1 lands in byte 0
  assign rot_w = {w_in[N_WORDS-1][7:0], w_in[N_WORDS-1][WORD_W-1:8]};

  for (genvar b = 0; b < N_BYTES; b++) begin : g_sbox
    aes_kstep_sbox u_sbox (
      .in_i (rot_w[b*8 +: 8]),
      .out_o(sub_w[b*8 +: 8])
    );
  end

  always_comb begin
    w_out[0] = w_in[0] ^ sub_w ^ {{(WORD_W-8){1'b0}}, round_const(round_i)};
    for (int i = 1; i < N_WORDS; i++) w_out[i] = w_in[i] ^ w_out[i-1];
  end
endmodule

// File: rtl/aes_kstep_ctrl.sv
module aes_kstep_ctrl #(
  parameter int VL_W  = 7,
  parameter int GRP_W = VL_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [3:0]       round_imm_i,
  input  logic [2:0]       sew_i,
  input  logic [VL_W-1:0]  vstart_i,
  input  logic [VL_W-1:0]  vl_i,
  output logic             rd_en_o,
  output logic [GRP_W-1:0] grp_o,
  output logic [3:0]       round_o,
  output logic             wr_en_o,
  output logic [GRP_W-1:0] wr_grp_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             illegal_o
);
  import aes_kstep_pkg::*;

  kstep_state_e     state_q;
  logic [GRP_W-1:0] grp_q, last_q, wr_grp_q;
  logic [3:0]       round_q;
  logic             wr_en_q, done_q, illegal_q;
  logic             cfg_ok, empty;

  assign cfg_ok = (sew_i == SEW_E32) && (vstart_i[1:0] == 2'b00) && (vl_i[1:0] == 2'b00);
  assign empty  = vstart_i >= vl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      grp_q     <= '0;
      last_q    <= '0;
      wr_grp_q  <= '0;
      round_q   <= 4'd1;
      wr_en_q   <= 1'b0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      wr_en_q   <= 1'b0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (!cfg_ok) illegal_q <= 1'b1;
          else if (empty) done_q <= 1'b1;
          else begin
            grp_q   <= vstart_i[VL_W-1:2];
            last_q  <= vl_i[VL_W-1:2] - GRP_W'(1);
            round_q <= fold_round(round_imm_i);
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          wr_en_q  <= 1'b1;
          wr_grp_q <= grp_q;
          if (grp_q == last_q) state_q <= ST_FIN;
          else grp_q <= grp_q + GRP_W'(1);
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en_o   = (state_q == ST_RUN);
  assign grp_o     = grp_q;
  assign round_o   = round_q;
  assign wr_en_o   = wr_en_q;
  assign wr_grp_o  = wr_grp_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign illegal_o = illegal_q;

  p_round_folded_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (round_q >= 4'd1 && round_q <= 4'd10));
  p_illegal_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && !rd_en_o));
  p_empty_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(busy_o)) |-> !wr_en_o);
  p_wr_ascending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_grp_o == $past(wr_grp_o) + GRP_W'(1)));
  p_wr_after_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> $past(rd_en_o));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_flags_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));
  p_wr_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_grp_o <= last_q));
  p_busy_ignores_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && state_q == ST_RUN) |=> $stable(last_q));
endmodule

// File: rtl/aes_kstep_unit.sv
module aes_kstep_unit #(
  parameter int MAX_ELEMS = 64,
  parameter int VL_W  = $clog2(MAX_ELEMS + 1),
  parameter int GRP_W = VL_W - 2,
  parameter int EGW   = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [3:0]       round_imm_i,
  input  logic [2:0]       sew_i,
  input  logic [VL_W-1:0]  vstart_i,
  input  logic [VL_W-1:0]  vl_i,
  output logic             rd_en_o,
  output logic [GRP_W-1:0] rd_grp_o,
  input  logic [EGW-1:0]   rd_data_i,
  output logic             wr_en_o,
  output logic [GRP_W-1:0] wr_grp_o,
  output logic [EGW-1:0]   wr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             illegal_o
);
  logic [3:0]     round;
  logic [EGW-1:0] next_key;
  logic [EGW-1:0] wr_data_q;

  aes_kstep_ctrl #(.VL_W(VL_W), .GRP_W(GRP_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .round_imm_i(round_imm_i),
    .sew_i      (sew_i),
    .vstart_i   (vstart_i),
    .vl_i       (vl_i),
    .rd_en_o    (rd_en_o),
    .grp_o      (rd_grp_o),
    .round_o    (round),
    .wr_en_o    (wr_en_o),
    .wr_grp_o   (wr_grp_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .illegal_o  (illegal_o)
  );

  aes_kstep_core #(.WORD_W(32), .N_WORDS(EGW / 32)) u_core (
    .round_i(round),
    .key_i  (rd_data_i),
    .key_o  (next_key)
  );

  // register the result: keeps S-box path off the write port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_data_q <= '0;
    else if (rd_en_o) wr_data_q <= next_key;
  end

  assign wr_data_o = wr_data_q;

  p_reset_quiet_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (!wr_en_o && !rd_en_o && !done_o && !illegal_o && !busy_o));
  p_wr_data_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(rd_en_o)) |-> $stable(wr_data_o));
endmodule

// File: tb/aes_kstep_unit_tb.sv
module aes_kstep_unit_tb;
  localparam int VL_W  = 7;
  localparam int GRP_W = 5;
  localparam int NGRP  = 16;
  localparam logic [127:0] SENT = {4{32'hA5A5_5A5A}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [3:0] round_imm_i = '0;
  logic [2:0] sew_i = '0;
  logic [VL_W-1:0] vstart_i = '0, vl_i = '0;
  logic rd_en_o, wr_en_o, busy_o, done_o, illegal_o;
  logic [GRP_W-1:0] rd_grp_o, wr_grp_o;
  logic [127:0] rd_data_i, wr_data_o;

  logic [127:0] src_mem [NGRP];
  logic [127:0] dst_mem [NGRP];
  logic [7:0]   sb [256];
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  aes_kstep_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .round_imm_i(round_imm_i),
    .sew_i(sew_i), .vstart_i(vstart_i), .vl_i(vl_i), .rd_en_o(rd_en_o),
    .rd_grp_o(rd_grp_o), .rd_data_i(rd_data_i), .wr_en_o(wr_en_o),
    .wr_grp_o(wr_grp_o), .wr_data_o(wr_data_o), .busy_o(busy_o),
    .done_o(done_o), .illegal_o(illegal_o)
  );

  assign rd_data_i = src_mem[rd_grp_o[3:0]];

  always @(posedge clk) if (wr_en_o) dst_mem[wr_grp_o[3:0]] <= wr_data_o;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  // S-box from generator walk, independent of the design's inverse
  task automatic build_sbox();
    logic [7:0] p, q;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [127:0] model(input logic [3:0] rnd, input logic [127:0] k);
    logic [3:0] eff; logic [7:0] rc; logic [31:0] rot, sub, w4, w5, w6, w7;
    eff = (rnd == 0 || rnd > 10) ? rnd ^ 4'h8 : rnd;
    rc = 8'h01;
    for (int i = 1; i < int'(eff); i++) rc = xt(rc);
    rot = {k[103:96], k[127:104]};
    sub = {sb[rot[31:24]], sb[rot[23:16]], sb[rot[15:8]], sb[rot[7:0]]};
    w4 = k[31:0] ^ sub ^ {24'h0, rc};
    w5 = k[63:32] ^ w4; w6 = k[95:64] ^ w5; w7 = k[127:96] ^ w6;
    return {w7, w6, w5, w4};
  endfunction

  task automatic fill(input int seed);
    for (int g = 0; g < NGRP; g++) begin
      src_mem[g] = {32'h9e3779b9 * (g + seed + 1), 32'h7f4a7c15 ^ (g * 977 + seed),
                    32'hc2b2ae35 * (g + 3) ^ seed, 32'h85ebca6b + g * seed};
      dst_mem[g] = SENT;
    end
  endtask

  // kind: 0 legal run, 1 illegal, 2 empty
  task automatic run_op(input logic [3:0] rnd, input logic [2:0] sew, input int vs,
                        input int vl, input int kind, input bit poke, input string ftag);
    int n, cyc, nxt, exp_cyc, g0;
    string dtag;
    dtag = (rnd == 0 || rnd > 10) ? "R1" : "R2";
    n = (kind == 0) ? (vl - vs) / 4 : 0;
    exp_cyc = (kind == 0) ? n + 2 : 1;
    g0 = vs / 4;
    @(negedge clk);
    start_i = 1'b1; round_imm_i = rnd; sew_i = sew;
    vstart_i = VL_W'(vs); vl_i = VL_W'(vl);
    @(negedge clk);
    start_i = 1'b0; sew_i = 3'd0; round_imm_i = 4'd5; vstart_i = '0; vl_i = 7'd8;
    cyc = 1; nxt = g0;
    while (!(done_o || illegal_o) && cyc < 300) begin
      if (wr_en_o) begin
        chk(wr_grp_o == GRP_W'(nxt), "R6", "write order", 128'(wr_grp_o), 128'(nxt));
        chk(wr_data_o == model(rnd, src_mem[wr_grp_o[3:0]]), dtag, "group result",
            wr_data_o, model(rnd, src_mem[wr_grp_o[3:0]]));
        nxt++;
      end
      start_i = poke && (cyc == 2 || cyc == n + 1);
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    if (kind == 1)
      chk(illegal_o && !done_o, ftag, "illegal flag", {illegal_o, done_o}, 2'b10);
    else
      chk(done_o && !illegal_o, ftag, "done flag", {illegal_o, done_o}, 2'b01);
    chk(cyc == exp_cyc, "R7", "flag latency", 128'(cyc), 128'(exp_cyc));
    chk(nxt - g0 == n, "R8", "write count", 128'(nxt - g0), 128'(n));
    begin
      bit ok; ok = 1'b1;
      for (int g = 0; g < NGRP; g++) begin
        logic [127:0] e;
        e = (g >= g0 && g < g0 + n) ? model(rnd, src_mem[g]) : SENT;
        if (dst_mem[g] !== e) begin
          ok = 1'b0;
          $display("FAIL R8 group %0d: actual %h expected %h", g, dst_mem[g], e);
        end
      end
      n_chk++; if (!ok) n_err++;
    end
    @(negedge clk);
    chk(!done_o && !illegal_o && !wr_en_o, "R7", "flag pulse width",
        {done_o, illegal_o, wr_en_o}, 3'b000);
  endtask

  localparam int NV = 14;
  // {round, sew, vstart, vl, kind}
  localparam logic [22:0] VEC [NV] = '{
    {4'd1,  3'd2, 7'd0,  7'd4,  2'd0},
    {4'd10, 3'd2, 7'd0,  7'd64, 2'd0},
    {4'd0,  3'd2, 7'd8,  7'd24, 2'd0},
    {4'd11, 3'd2, 7'd4,  7'd12, 2'd0},
    {4'd15, 3'd2, 7'd60, 7'd64, 2'd0},
    {4'd12, 3'd2, 7'd0,  7'd8,  2'd0},
    {4'd9,  3'd2, 7'd32, 7'd40, 2'd0},
    {4'd5,  3'd0, 7'd0,  7'd16, 2'd1},
    {4'd5,  3'd3, 7'd0,  7'd16, 2'd1},
    {4'd2,  3'd2, 7'd2,  7'd8,  2'd1},
    {4'd2,  3'd2, 7'd0,  7'd6,  2'd1},
    {4'd6,  3'd2, 7'd5,  7'd2,  2'd1},
    {4'd4,  3'd2, 7'd16, 7'd16, 2'd2},
    {4'd4,  3'd2, 7'd20, 7'd8,  2'd2}
  };

  initial begin
    #1500000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    build_sbox();
    fill(0);
    repeat (3) @(negedge clk);
    chk(!rd_en_o && !wr_en_o && !done_o && !illegal_o && !busy_o, "R10", "reset outputs",
        {rd_en_o, wr_en_o, done_o, illegal_o, busy_o}, 5'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // known-answer round 1 step
    fill(1);
    src_mem[0] = {32'h3c4fcf09, 32'h8815f7ab, 32'ha6d2ae28, 32'h16157e2b};
    run_op(4'd1, 3'd2, 0, 4, 0, 1'b0, "R7");
    chk(dst_mem[0] == {32'h05766c2a, 32'h3939a323, 32'hb12c5488, 32'h17fefaa0}, "R2",
        "known answer", dst_mem[0],
        {32'h05766c2a, 32'h3939a323, 32'hb12c5488, 32'h17fefaa0});

    for (int i = 0; i < NV; i++) begin
      logic [1:0] kd;
      string ft;
      kd = VEC[i][1:0];
      ft = (kd == 2'd2) ? "R5" : (kd == 2'd0) ? "R7" :
           (VEC[i][18:16] != 3'd2) ? "R3" : "R4";
      fill(i * 7 + 3);
      run_op(VEC[i][22:19], VEC[i][18:16], int'(VEC[i][15:9]), int'(VEC[i][8:2]),
             int'(kd), 1'b0, ft);
    end

    // R9: start pulses (with an illegal code) while busy and in the final cycle
    fill(99);
    run_op(4'd3, 3'd2, 0, 16, 0, 1'b1, "R9");
    fill(100);
    run_op(4'd14, 3'd2, 12, 28, 0, 1'b1, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule